// File: doc/BRIEF.md
# Dual-Mode System Clock-Rate Controller

This block turns one free-running base clock into three clock-enable strobes. A bus-master enable slows the processor side alone. A chip-wide enable slows every consumer. A pin enable drives the external clock-output pin. Software sets the rate through one 8-bit control register. A mode bit in that register decides what a 3-bit select field means. With the mode bit clear, the select divides only the bus master. With the mode bit set, the select divides the whole chip, and the bus master runs inside the chip enable.

The register rejects writes that are not legal. A legal write changes the mode bit and the select field in separate steps, and uses only a code defined for the mode in force. Any write that breaks these rules sets a sticky error flag.

Each strobe comes from its own divider, and each divider is a small state machine with two states:
- `DV_FULL`: the enable is held high.
- `DV_COUNT`: a phase counter runs, and the enable is high on its last count.

The divider moves between states on named transitions:
- `T_HOLD`: full to full.
- `T_START`: full to count.
- `T_STEP`: count to count, with no wrap.
- `T_RELOAD`: wrap, then count again at a new or the same ratio.
- `T_STOP`: wrap, then back to full.

A new ratio is adopted only on a wrap. Clock edges therefore never come too close together while the rate changes.

Top module: `clk_rate_ctrl`

## Requirements
- R1: After reset the register reads 0x00, `err_flag` is 0, and `bm_en`, `chip_en` and `pin_en` are all high.
- R2: `rd_data` shows the mode bit at bit 5 and the select field at bits 2..0. Bits 7, 6, 4 and 3 always read 0, whatever was written to them.
- R3: With mode 0, select codes 1 to 5 make `bm_en` high for one base cycle in every 2, 4, 8, 16 or 32 cycles (2^code). `chip_en` stays high in this mode.
- R4: With mode 1, select codes 1 to 3 make `chip_en` high for one base cycle in every 2, 4 or 8 cycles (2^code). In this mode `bm_en` equals `chip_en`.
- R5: Select code 0, in either mode, holds every enable high continuously.
- R6: A write that changes the mode bit and also presents a select value different from the stored one applies only the mode bit. The stored select is kept, and `err_flag` is set.
- R7: A write is rejected whole, with the register unchanged and `err_flag` set, when its resulting select code is undefined for its resulting mode. Undefined codes are 6 and 7 in mode 0, and 4 to 7 in mode 1.
- R8: `err_flag` stays set until a cycle with `err_clr` high and no new error. A new error in the same cycle as `err_clr` wins, so the flag stays set.
- R9: A divider adopts a new ratio only in the cycle its enable is high, which ends the current period. No enable pulse is ever longer than one cycle in a divided mode, and no period is cut short.
- R10: `pin_en` equals `chip_en` in every cycle.
- R11: `bm_en` is never high while `chip_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| err_clr | input | 1 | Clears the sticky error flag |
| rd_data | output | 8 | Register contents, reserved bits zero |
| err_flag | output | 1 | Sticky illegal-write indicator |
| bm_en | output | 1 | Bus-master clock enable |
| chip_en | output | 1 | Chip-wide clock enable |
| pin_en | output | 1 | External clock-output pin enable |

## Verification
A divider whose phase counter or adopted ratio is wrong shows up on its enable within one period of the intended ratio. That means at most 32 base cycles for the bus master and 8 for the chip. The error takes the form of a pulse that comes early, comes late or is doubled. A corrupted register or error bit is visible at `rd_data` or `err_flag` in the cycle right after the write. The bench compares every output against a behavioural model in every cycle, so any such divergence is caught at its first cycle.

// File: rtl/clkrate_pkg.sv
package clkrate_pkg;
    localparam int REG_W        = 8;
    localparam int MODE_POS     = 5;
    localparam int SEL_W        = 3;
    localparam int BM_MAX_LOG   = 5;
    localparam int CHIP_MAX_LOG = 3;

    typedef enum logic {DV_FULL, DV_COUNT} div_state_e;

    typedef struct packed {
        logic             mode;
        logic [SEL_W-1:0] sel;
    } rate_ctl_t;
endpackage

// File: rtl/clkrate_regs.sv
module clkrate_regs
    import clkrate_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             err_clr,
    output rate_ctl_t        ctl,
    output logic             err,
    output logic [REG_W-1:0] rd_data
);
    logic             w_mode;
    logic [SEL_W-1:0] w_sel;
    logic             both_change;
    logic [SEL_W-1:0] cand_sel;
    logic             cand_ok;
    logic             set_err;

    always_comb begin
        w_mode      = wr_data[MODE_POS];
        w_sel       = wr_data[SEL_W-1:0];
        both_change = (w_mode != ctl.mode) && (w_sel != ctl.sel);
        cand_sel    = both_change ? ctl.sel : w_sel;
        cand_ok     = w_mode ? (cand_sel <= SEL_W'(CHIP_MAX_LOG))
                             : (cand_sel <= SEL_W'(BM_MAX_LOG));
        set_err     = wr_en && (both_change || !cand_ok);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl <= '0;
            err <= 1'b0;
        end else begin
            if (wr_en && cand_ok) begin
                ctl.mode <= w_mode;
                ctl.sel  <= cand_sel;
            end
            if (set_err)      err <= 1'b1;
            else if (err_clr) err <= 1'b0;
        end
    end

    always_comb begin
        rd_data                = '0;
        rd_data[MODE_POS]      = ctl.mode;
        rd_data[SEL_W-1:0]     = ctl.sel;
    end

    // R6: mode and select changed together leaves select untouched and flags
    a_r6_sel_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[MODE_POS] != ctl.mode && wr_data[SEL_W-1:0] != ctl.sel)
        |=> ($stable(ctl.sel) && err));

    // R7: undefined mode-0 code leaves register unchanged
    a_r7_reject_m0: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[MODE_POS] && !ctl.mode &&
         wr_data[SEL_W-1:0] > SEL_W'(BM_MAX_LOG)) |=> ($stable(ctl) && err));

    // R8: flag is sticky without a clear
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !err_clr) |=> err);
endmodule

// File: rtl/clkrate_divider.sv
module clkrate_divider
    import clkrate_pkg::*;
#(
    parameter int MAX_LOG = 5,
    parameter int LOG_W   = 3,
    localparam int CW     = (MAX_LOG < 1) ? 1 : MAX_LOG
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LOG_W-1:0] tgt_log,
    output logic             en
);
    div_state_e       state, state_n;
    logic [LOG_W-1:0] act_log, act_n;
    logic [CW-1:0]    cnt, cnt_n;
    logic [LOG_W-1:0] tgt_c;
    logic [CW:0]      span;
    logic [CW:0]      last_w;
    logic             wrap;

    always_comb begin
        tgt_c  = (tgt_log > LOG_W'(MAX_LOG)) ? LOG_W'(MAX_LOG) : tgt_log;
        span   = (CW+1)'(1) << act_log;
        last_w = span - (CW+1)'(1);
        wrap   = (state == DV_FULL) || (cnt == last_w[CW-1:0]);
    end

    // next-state logic: T_HOLD, T_START, T_STEP, T_RELOAD, T_STOP
    always_comb begin
        state_n = state;
        act_n   = act_log;
        cnt_n   = cnt;
        unique case (state)
            DV_FULL: begin
                cnt_n   = '0;
                act_n   = tgt_c;
                state_n = (tgt_c == '0) ? DV_FULL : DV_COUNT;
            end
            DV_COUNT: begin
                if (wrap) begin
                    cnt_n   = '0;
                    act_n   = tgt_c;
                    state_n = (tgt_c == '0) ? DV_FULL : DV_COUNT;
                end else begin
                    cnt_n   = cnt + CW'(1);
                end
            end
            default: begin
                state_n = DV_FULL;
                act_n   = '0;
                cnt_n   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= DV_FULL;
            act_log <= '0;
            cnt     <= '0;
        end else begin
            state   <= state_n;
            act_log <= act_n;
            cnt     <= cnt_n;
        end
    end

    always_comb en = wrap;

    // R9: ratio only changes at the end of a period
    a_r9_hold_ratio: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(act_log));

    // R9: a divided period never carries two adjacent pulses
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tgt_c != '0) |=> !en);
endmodule

// File: rtl/clk_rate_ctrl.sv
module clk_rate_ctrl
    import clkrate_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             err_clr,
    output logic [REG_W-1:0] rd_data,
    output logic             err_flag,
    output logic             bm_en,
    output logic             chip_en,
    output logic             pin_en
);
    rate_ctl_t        ctl;
    logic [SEL_W-1:0] bm_tgt;
    logic [SEL_W-1:0] chip_tgt;
    logic             bm_raw;
    logic             chip_raw;

    clkrate_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .err_clr (err_clr),
        .ctl     (ctl),
        .err     (err_flag),
        .rd_data (rd_data)
    );

    always_comb begin
        bm_tgt   = ctl.mode ? '0      : ctl.sel;
        chip_tgt = ctl.mode ? ctl.sel : '0;
    end

    clkrate_divider #(.MAX_LOG(BM_MAX_LOG), .LOG_W(SEL_W)) u_bm_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .tgt_log (bm_tgt),
        .en      (bm_raw)
    );

    clkrate_divider #(.MAX_LOG(CHIP_MAX_LOG), .LOG_W(SEL_W)) u_chip_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .tgt_log (chip_tgt),
        .en      (chip_raw)
    );

    always_comb begin
        chip_en = chip_raw;
        pin_en  = chip_raw;
        bm_en   = bm_raw && chip_raw;
    end

    // R10: pin strobe tracks the chip strobe
    a_r10_pin_follows: assert property (@(posedge clk) disable iff (!rst_n)
        pin_en == chip_en);

    // R11: bus master never ticks outside a chip tick
    a_r11_bm_inside_chip: assert property (@(posedge clk) disable iff (!rst_n)
        bm_en |-> chip_en);
endmodule

// File: tb/tb_clk_rate_ctrl.sv
module tb_clk_rate_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       err_clr = 1'b0;
    logic [7:0] rd_data;
    logic       err_flag, bm_en, chip_en, pin_en;

    int checks = 0;
    int errors = 0;
    bit running = 1'b0;

    int m_mode, m_sel, m_err;
    int bm_act, bm_cnt, ch_act, ch_cnt;

    always #10 clk = ~clk;

    clk_rate_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .err_clr(err_clr), .rd_data(rd_data), .err_flag(err_flag),
        .bm_en(bm_en), .chip_en(chip_en), .pin_en(pin_en)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference, advanced on every rising edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_sel = 0; m_err = 0;
            bm_act = 0; bm_cnt = 0; ch_act = 0; ch_cnt = 0;
        end else begin
            int tb, tc, nm, ns, cs;
            bit both, ok, seterr;
            tb = m_mode ? 0 : m_sel;
            tc = m_mode ? m_sel : 0;
            if (bm_cnt == (1 << bm_act) - 1) begin bm_act = tb; bm_cnt = 0; end
            else bm_cnt++;
            if (ch_cnt == (1 << ch_act) - 1) begin ch_act = tc; ch_cnt = 0; end
            else ch_cnt++;
            seterr = 1'b0;
            if (wr_en) begin
                nm = int'(wr_data[5]);
                ns = int'(wr_data[2:0]);
                both = (nm != m_mode) && (ns != m_sel);
                cs = both ? m_sel : ns;
                ok = nm ? (cs <= 3) : (cs <= 5);
                if (ok) begin
                    m_mode = nm; m_sel = cs;
                    if (both) seterr = 1'b1;
                end else seterr = 1'b1;
            end
            if (seterr) m_err = 1;
            else if (err_clr) m_err = 0;
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (running) begin
            bit e_ch, e_bm;
            int e_rd;
            e_ch = (ch_cnt == (1 << ch_act) - 1);
            e_bm = e_ch && (bm_cnt == (1 << bm_act) - 1);
            e_rd = (m_mode << 5) | m_sel;
            check(bm_en == e_bm, "R3 R9 bm_en", bm_en, e_bm);
            check(chip_en == e_ch, "R4 R9 chip_en", chip_en, e_ch);
            check(pin_en == e_ch, "R10 pin_en", pin_en, e_ch);
            check(rd_data == e_rd[7:0], "R2 rd_data", rd_data, e_rd);
            check(err_flag == m_err[0], "R8 err_flag", err_flag, m_err);
        end
    end

    task automatic wrc(input logic [7:0] d, input logic clr);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d; err_clr = clr;
        @(negedge clk);
        wr_en = 1'b0; err_clr = 1'b0;
    endtask

    task automatic clr_err();
        @(negedge clk);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        running = 1'b1;
        // R1 reset state
        check(rd_data == 8'h00, "R1 reset rd_data", rd_data, 0);
        check(err_flag == 1'b0, "R1 reset err", err_flag, 0);
        check(bm_en && chip_en && pin_en, "R1 R5 reset enables", {bm_en, chip_en, pin_en}, 7);
        idle(4);
        // R3 bus-master divide, switches mid-period
        wrc(8'h03, 1'b0);
        check(rd_data == 8'h03, "R3 sel3 write", rd_data, 8'h03);
        idle(30);
        wrc(8'h01, 1'b0);
        idle(20);
        wrc(8'h05, 1'b0);
        idle(70);
        // R7 undefined mode-0 code
        wrc(8'h06, 1'b0);
        check(rd_data == 8'h05, "R7 code6 rejected", rd_data, 8'h05);
        check(err_flag == 1'b1, "R7 err set", err_flag, 1);
        idle(3);
        check(err_flag == 1'b1, "R8 sticky", err_flag, 1);
        clr_err();
        check(err_flag == 1'b0, "R8 cleared", err_flag, 0);
        // R5 back to full speed
        wrc(8'h00, 1'b0);
        idle(40);
        check(bm_en && chip_en, "R5 full speed", {bm_en, chip_en}, 3);
        // R4 chip-wide divide
        wrc(8'h20, 1'b0);
        check(rd_data == 8'h20, "R4 mode1 sel0", rd_data, 8'h20);
        wrc(8'h23, 1'b0);
        idle(30);
        wrc(8'h22, 1'b0);
        idle(20);
        wrc(8'h25, 1'b0);
        check(rd_data == 8'h22, "R7 mode1 code5 rejected", rd_data, 8'h22);
        check(err_flag == 1'b1, "R7 mode1 err", err_flag, 1);
        // R8 error and clear in the same cycle: error wins
        wrc(8'h26, 1'b1);
        check(err_flag == 1'b1, "R8 set beats clear", err_flag, 1);
        clr_err();
        // R6 mode and select changed together
        wrc(8'h04, 1'b0);
        check(rd_data == 8'h02, "R6 select kept", rd_data, 8'h02);
        check(err_flag == 1'b1, "R6 err set", err_flag, 1);
        idle(20);
        clr_err();
        // R2 reserved bits ignored
        wrc(8'hDA, 1'b0);
        check(rd_data == 8'h02, "R2 reserved zero", rd_data, 8'h02);
        check(err_flag == 1'b0, "R2 no error", err_flag, 0);
        // R7 mode switch leaving an undefined code
        wrc(8'h05, 1'b0);
        idle(5);
        wrc(8'h25, 1'b0);
        check(rd_data == 8'h05, "R7 mode switch rejected", rd_data, 8'h05);
        check(err_flag == 1'b1, "R7 mode switch err", err_flag, 1);
        clr_err();
        idle(80);
        running = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule